// File: doc/BRIEF.md
# Tagged Register File Datapath

This block is a small transaction-driven datapath. It holds eight data registers of parameterised width. Each register has a 2-bit label that belongs to the host. The host issues one instruction per clock. An instruction carries a 2-bit tag, a 6-bit operation word and an immediate operand. The operation can load, subtract, XOR, AND or shift a register. It can also relabel a register, or return a register's contents together with its label.

Every instruction finishes in the cycle in which it is accepted. A later instruction therefore always sees the result of an earlier one, with no gap between them. A read answers on the response port one cycle after it is accepted, as a single-cycle pulse. The host uses the returned tag to match each result to the operands it came from. The block never interprets the tag.

Top module: `tagreg_proc`

## Requirements
- R1: After a synchronous active-low reset, every register value and every tag is zero, `rsp_valid` is low and `cmd_ready` is high.
- R2: `cmd_op[5:3]` selects the operation and `cmd_op[2:0]` selects the register. The codes are 0 load, 1 subtract, 2 XOR, 3 AND, 4 shift right, 5 shift left, 6 retag and 7 read.
- R3: A load (code 0) writes `cmd_data` into the register and replaces the register's tag with `cmd_tag`.
- R4: A subtract (code 1) writes the register minus `cmd_data`, wrapping modulo 2^DATA_W, and replaces the tag with `cmd_tag`.
- R5: XOR (code 2) and AND (code 3) combine the register with `cmd_data` bitwise and replace the tag with `cmd_tag`.
- R6: Shift right (code 4) and shift left (code 5) move the register by `cmd_data[1:0]` places (0 to 3) with zero fill. The tag is left unchanged.
- R7: Retag (code 6) sets the register's tag to `cmd_data[1:0]` and leaves its value unchanged.
- R8: A read (code 7) accepted at one edge raises `rsp_valid` for exactly the next cycle, with the register's value on `rsp_data` and its tag on `rsp_tag`. Whenever `rsp_valid` is low, `rsp_data` and `rsp_tag` are zero. A read changes no register and no tag.
- R9: `cmd_ready` stays high and one instruction is accepted on every cycle with `cmd_valid` high, with no limit on the run length. A cycle with `cmd_valid` low changes no register and no tag.
- R10: A read that immediately follows a write to the same register returns the value and tag written by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Instruction present this cycle |
| cmd_tag | input | 2 | Host tag of the instruction |
| cmd_op | input | 6 | Operation code [5:3] and register index [2:0] |
| cmd_data | input | DATA_W | Immediate operand |
| rsp_valid | output | 1 | Read result present |
| rsp_tag | output | 2 | Tag of the register that was read |
| rsp_data | output | DATA_W | Value of the register that was read |
| cmd_ready | output | 1 | Instructions may be issued |

## Verification
Two things can fall in the same cycle. A write to a register can update it at the same edge at which a read of that register is issued. A new instruction can also be accepted in the same cycle in which the previous read is being answered. The bench provokes both. It places a read directly behind a load, subtract, shift or retag of the same register, and it runs long unbroken streams of random instructions with reads mixed in. A behavioural model updates at every edge, and each response is compared with that model on every cycle. A response is therefore judged against the state after the preceding write, never the stale state.

// File: rtl/tagreg_pkg.sv
// Package: types shared by the tagged register datapath.
// Assumes: the operation word is a 3-bit code over a 3-bit register index.
package tagreg_pkg;

    localparam int TAG_W   = 2;
    localparam int OP_W    = 6;
    localparam int IDX_W   = 3;
    localparam int SHAMT_W = 2;

    typedef enum logic [2:0] {
        OPC_LOAD  = 3'd0,
        OPC_SUB   = 3'd1,
        OPC_XOR   = 3'd2,
        OPC_AND   = 3'd3,
        OPC_SHR   = 3'd4,
        OPC_SHL   = 3'd5,
        OPC_RETAG = 3'd6,
        OPC_READ  = 3'd7
    } opcode_e;

endpackage

// File: rtl/tagreg_decode.sv
// Module: splits an operation word into a code and a register index and
// raises the write enables for the value and the tag.
// Assumes: the enables are qualified by cmd_valid here and nowhere else.
module tagreg_decode
    import tagreg_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [OP_W-1:0]     cmd_op,
    output opcode_e             opcode,
    output logic [IDX_W-1:0]    reg_idx,
    output logic                val_we,
    output logic                tag_we,
    output logic                tag_from_data,
    output logic                rd_fire
);

    assign opcode  = opcode_e'(cmd_op[OP_W-1:IDX_W]);
    assign reg_idx = cmd_op[IDX_W-1:0];

    // Derive the per-operation enables for the register file.
    always_comb begin
        val_we        = 1'b0;
        tag_we        = 1'b0;
        tag_from_data = 1'b0;
        rd_fire       = 1'b0;
        if (cmd_valid) begin
            unique case (opcode)
                OPC_LOAD, OPC_SUB, OPC_XOR, OPC_AND: begin
                    val_we = 1'b1;
                    tag_we = 1'b1;
                end
                OPC_SHR, OPC_SHL: val_we = 1'b1;
                OPC_RETAG: begin
                    tag_we        = 1'b1;
                    tag_from_data = 1'b1;
                end
                OPC_READ: rd_fire = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tagreg_alu.sv
// Module: computes the new register value for the value-changing operations.
// Assumes: the shift amount is the low SHAMT_W bits of the operand; shifts
// fill with zeros and subtraction wraps at DATA_W bits.
module tagreg_alu
    import tagreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e             opcode,
    input  logic [DATA_W-1:0]   cur_val,
    input  logic [DATA_W-1:0]   operand,
    output logic [DATA_W-1:0]   new_val
);

    logic [SHAMT_W-1:0] shamt;
    assign shamt = operand[SHAMT_W-1:0];

    // Select the result of the requested operation.
    always_comb begin
        unique case (opcode)
            OPC_LOAD: new_val = operand;
            OPC_SUB:  new_val = cur_val - operand;
            OPC_XOR:  new_val = cur_val ^ operand;
            OPC_AND:  new_val = cur_val & operand;
            OPC_SHR:  new_val = cur_val >> shamt;
            OPC_SHL:  new_val = cur_val << shamt;
            default:  new_val = cur_val;
        endcase
    end

endmodule

// File: rtl/tagreg_file.sv
// Module: DEPTH registers of DATA_W bits, each paired with a tag, and one
// shared index that addresses both the write and the combinational read.
// Assumes: at most one entry is written per cycle; the read returns the
// state before the current edge.
module tagreg_file
    import tagreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       idx,
    input  logic                val_we,
    input  logic [DATA_W-1:0]   val_in,
    input  logic                tag_we,
    input  logic [TAG_W-1:0]    tag_in,
    output logic [DATA_W-1:0]   rd_val,
    output logic [TAG_W-1:0]    rd_tag
);

    logic [DATA_W-1:0] vals [DEPTH];
    logic [TAG_W-1:0]  tags [DEPTH];
    logic [DEPTH-1:0]  hit;

    // One select line per entry.
    for (genvar e = 0; e < DEPTH; e++) begin : g_hit
        assign hit[e] = (idx == AW'(e));
    end

    // Update the addressed entry; clear every entry on reset.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (!rst_n) begin
                vals[e] <= '0;
                tags[e] <= '0;
            end else begin
                if (val_we && hit[e]) vals[e] <= val_in;
                if (tag_we && hit[e]) tags[e] <= tag_in;
            end
        end
    end

    assign rd_val = vals[idx];
    assign rd_tag = tags[idx];

endmodule

// File: rtl/tagreg_proc.sv
// Module: top of the tagged register datapath. Each valid instruction
// completes at the edge that accepts it; a read is answered one cycle later.
// Assumes: DATA_W is at least TAG_W and SHAMT_W; the host may issue every cycle.
module tagreg_proc
    import tagreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_tag,
    input  logic [5:0]          cmd_op,
    input  logic [DATA_W-1:0]   cmd_data,
    output logic                rsp_valid,
    output logic [1:0]          rsp_tag,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                cmd_ready
);

    localparam int NREGS = 1 << IDX_W;

    opcode_e            opcode;
    logic [IDX_W-1:0]   reg_idx;
    logic               val_we, tag_we, tag_from_data, rd_fire;
    logic [DATA_W-1:0]  cur_val, new_val;
    logic [TAG_W-1:0]   cur_tag, tag_in;

    tagreg_decode u_dec (
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .opcode        (opcode),
        .reg_idx       (reg_idx),
        .val_we        (val_we),
        .tag_we        (tag_we),
        .tag_from_data (tag_from_data),
        .rd_fire       (rd_fire)
    );

    tagreg_file #(.DATA_W(DATA_W), .DEPTH(NREGS)) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (reg_idx),
        .val_we (val_we),
        .val_in (new_val),
        .tag_we (tag_we),
        .tag_in (tag_in),
        .rd_val (cur_val),
        .rd_tag (cur_tag)
    );

    tagreg_alu #(.DATA_W(DATA_W)) u_alu (
        .opcode  (opcode),
        .cur_val (cur_val),
        .operand (cmd_data),
        .new_val (new_val)
    );

    assign tag_in = tag_from_data ? cmd_data[TAG_W-1:0] : cmd_tag;

    // Register the read response; keep it at zero between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= rd_fire;
            rsp_data  <= rd_fire ? cur_val : '0;
            rsp_tag   <= rd_fire ? cur_tag : '0;
        end
    end

    // Single-cycle completion means the block never has to push back.
    assign cmd_ready = 1'b1;

endmodule

// File: rtl/tagreg_chk.sv
// Module: protocol checker for tagreg_proc, attached by bind below.
// Assumes: it sees only the top-level ports of the datapath.
module tagreg_chk #(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [1:0]          cmd_tag,
    input logic [5:0]          cmd_op,
    input logic [DATA_W-1:0]   cmd_data,
    input logic                rsp_valid,
    input logic [1:0]          rsp_tag,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                cmd_ready
);

    logic past_ok;
    logic is_read;

    // Mark that the previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign is_read = cmd_valid && (cmd_op[5:3] == 3'b111);

    AST_READY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready); // R9

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !rsp_valid); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == '0 && rsp_tag == '0)); // R8

    AST_LOAD_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_read && $past(cmd_valid)
            && $past(cmd_op) == {3'b000, cmd_op[2:0]})
        |=> (rsp_data == $past(cmd_data, 2) && rsp_tag == $past(cmd_tag, 2))); // R10

    AST_RETAG_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_read && $past(cmd_valid)
            && $past(cmd_op) == {3'b110, cmd_op[2:0]})
        |=> (rsp_tag == $past(cmd_data[1:0], 2))); // R7

endmodule

bind tagreg_proc tagreg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_tag   (cmd_tag),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .cmd_ready (cmd_ready)
);

// File: tb/test_tagreg_proc.sv
// Bench: drives instructions at the falling edge, updates a behavioural
// model at each rising edge and compares every output at the next fall.
module test_tagreg_proc;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_tag = '0;
    logic [5:0]    cmd_op = '0;
    logic [W-1:0]  cmd_data = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_tag;
    logic [W-1:0]  rsp_data;
    logic          cmd_ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_val [8];
    logic [1:0]   m_tag [8];
    logic         e_valid;
    logic [W-1:0] e_data;
    logic [1:0]   e_tag;

    always #10 clk = ~clk;

    tagreg_proc #(.DATA_W(W)) i_tagreg_proc (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_tag(cmd_tag),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .cmd_ready(cmd_ready)
    );

    task automatic compare(input string req);
        checks++;
        if (rsp_valid !== e_valid || rsp_data !== e_data
            || rsp_tag !== e_tag || cmd_ready !== 1'b1) begin
            errors++;
            $display("FAIL %s: got v=%b d=%h t=%0d rdy=%b, expected v=%b d=%h t=%0d rdy=1",
                     req, rsp_valid, rsp_data, rsp_tag, cmd_ready,
                     e_valid, e_data, e_tag);
        end
    endtask

    // Apply one instruction, advance the model at the edge, then check.
    task automatic step(input logic v, input logic [1:0] t, input int opc,
                        input int r, input logic [W-1:0] d, input string req);
        cmd_valid = v;
        cmd_tag   = t;
        cmd_op    = {3'(opc), 3'(r)};
        cmd_data  = d;
        @(posedge clk);
        e_valid = 1'b0;
        e_data  = '0;
        e_tag   = '0;
        if (v) begin
            case (opc)
                0: begin m_val[r] = d;                  m_tag[r] = t; end
                1: begin m_val[r] = m_val[r] - d;       m_tag[r] = t; end
                2: begin m_val[r] = m_val[r] ^ d;       m_tag[r] = t; end
                3: begin m_val[r] = m_val[r] & d;       m_tag[r] = t; end
                4: m_val[r] = m_val[r] >> d[1:0];
                5: m_val[r] = m_val[r] << d[1:0];
                6: m_tag[r] = d[1:0];
                default: begin
                    e_valid = 1'b1;
                    e_data  = m_val[r];
                    e_tag   = m_tag[r];
                end
            endcase
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_tag[i] = '0; end
        e_valid = 1'b0; e_data = '0; e_tag = '0;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        // R1: every register reads back zero with tag zero.
        for (int r = 0; r < 8; r++) step(1, 2'd3, 7, r, 16'hFFFF, "R1 reset contents");
        // R3, R2: loads into distinct registers with distinct tags.
        step(1, 2'd1, 0, 0, 16'h1234, "R3 load");
        step(1, 2'd2, 0, 5, 16'hA5A5, "R3 load");
        step(1, 2'd3, 0, 7, 16'h8001, "R3 load");
        step(1, 2'd0, 7, 0, 16'h0000, "R3 read back");
        step(1, 2'd0, 7, 5, 16'h0000, "R2 index");
        step(1, 2'd0, 7, 7, 16'h0000, "R3 read back");
        // R4: subtract with wraparound.
        step(1, 2'd0, 0, 1, 16'h0005, "R4 setup");
        step(1, 2'd2, 1, 1, 16'h0007, "R4 sub wrap");
        step(1, 2'd0, 7, 1, 16'h0000, "R4 sub result");
        // R5: XOR and AND.
        step(1, 2'd3, 2, 5, 16'hFF00, "R5 xor");
        step(1, 2'd0, 7, 5, 16'h0000, "R5 xor result");
        step(1, 2'd1, 3, 5, 16'h0FF0, "R5 and");
        step(1, 2'd0, 7, 5, 16'h0000, "R5 and result");
        // R6: shifts by 0..3, upper operand bits ignored, tag kept.
        step(1, 2'd2, 0, 2, 16'hF0F1, "R6 setup");
        step(1, 2'd1, 4, 2, 16'hFFFE, "R6 shr 2");
        step(1, 2'd0, 7, 2, 16'h0000, "R6 shr result");
        step(1, 2'd3, 5, 2, 16'h0007, "R6 shl 3");
        step(1, 2'd0, 7, 2, 16'h0000, "R6 shl result");
        step(1, 2'd0, 4, 2, 16'h0004, "R6 shr 0");
        step(1, 2'd0, 7, 2, 16'h0000, "R6 shr 0 result");
        step(1, 2'd0, 5, 2, 16'h0001, "R6 shl 1");
        step(1, 2'd0, 7, 2, 16'h0000, "R6 shl 1 result");
        // R7: retag changes only the tag.
        step(1, 2'd0, 6, 7, 16'h0002, "R7 retag");
        step(1, 2'd1, 7, 7, 16'h0000, "R7 retag result");
        // R9: idle cycles with write opcodes leave state unchanged.
        step(0, 2'd3, 0, 7, 16'hDEAD, "R9 idle load");
        step(0, 2'd3, 6, 7, 16'h0001, "R9 idle retag");
        step(1, 2'd0, 7, 7, 16'h0000, "R9 state kept");
        // R8: back-to-back reads, then a gap.
        step(1, 2'd0, 7, 0, 16'h0000, "R8 read pulse");
        step(1, 2'd0, 7, 1, 16'h0000, "R8 read pulse");
        step(0, 2'd0, 7, 1, 16'h0000, "R8 quiet after read");
        step(1, 2'd0, 7, 1, 16'h0000, "R8 read changes nothing");
        // R10: read directly behind writes to the same register.
        step(1, 2'd2, 0, 3, 16'h4321, "R10 load");
        step(1, 2'd0, 7, 3, 16'h0000, "R10 load then read");
        step(1, 2'd1, 1, 3, 16'h0021, "R10 sub");
        step(1, 2'd0, 7, 3, 16'h0000, "R10 sub then read");
        step(1, 2'd0, 6, 3, 16'h0003, "R10 retag");
        step(1, 2'd0, 7, 3, 16'h0000, "R10 retag then read");
        // R9: long unbroken random stream.
        for (int k = 0; k < 300; k++) begin
            step(1, 2'($urandom), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), W'($urandom), "R9 stream");
        end
        step(0, 2'd0, 0, 0, 16'h0000, "R9 stream end");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule